// File: doc/BRIEF.md
# Two-Port Bus Transceiver with Latch/Register Storage per Direction

This block moves an 18-bit word between two ports, A and B, in both directions at once. Each direction has its own single storage element. A latch-enable level and a strobe input decide what that element does in each cycle. With the latch enable high, the element follows its source port. With the latch enable low, a rising edge on the strobe captures the source port. With the latch enable low and the strobe steady, the element keeps its contents.

Each direction also has an output enable. It decides whether the far port is driven or released. The A-to-B enable is active high and the B-to-A enable is active low. The tri-state pins appear as a data vector plus a drive flag per port, so the block fits a fully synchronous core.

The strobe inputs are treated as ordinary signals and sampled on the system clock. A path's strobe edge is found by comparing the strobe with its value in the previous system cycle.

Each path selects one of three modes in every system cycle:
- PASS: the latch enable is high, and the element loads the source port.
- CAPTURE: the latch enable is low and a strobe rising edge is seen, and the element loads the source port.
- HOLD: the latch enable is low and there is no rising edge, and the element keeps its value.

From any mode the path may move to any other mode in the next cycle; only the two control levels decide. Reset forces both elements to zero and both drive flags low.

Top module: `dual_path_bus_xcvr`

## Requirements
- R1: While `rst_n` is low, `b_data`, `a_data`, `b_drive` and `a_drive` are all 0.
- R2: PASS. With `ab_le` high at a system clock rising edge, `b_data` equals the `a_port` value sampled at that edge, one cycle later. The same applies to `ba_le`, `b_port` and `a_data`.
- R3: CAPTURE. With `ab_le` low, a strobe sample of `ab_stb` = 1 whose previous-cycle sample was 0 loads `a_port` into the A-to-B element at that edge.
- R4: HOLD. With `ab_le` low and `ab_stb` steady, either low or high, the element and `b_data` keep their value whatever `a_port` does.
- R5: A falling edge on the strobe never loads data. When the latch enable falls, either with the strobe high or with it low, the element keeps the last value it passed through.
- R6: `b_drive` equals the `ab_oe` level sampled at the previous edge. 1 means port B is driven.
- R7: `a_drive` equals the inverse of the `ba_oe_n` level sampled at the previous edge. `ba_oe_n` = 0 means port A is driven.
- R8: Releasing a port does not stop its storage. The element keeps following the PASS, CAPTURE and HOLD rules, and when drive returns the port shows the updated value.
- R9: The two directions are independent. No control or data input of one path changes the other path's outputs.
- R10: The previous strobe sample resets to 1. A strobe that is already high when reset is released is therefore not taken as a rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_port | input | WIDTH | Data arriving on port A (source of the A-to-B path) |
| b_port | input | WIDTH | Data arriving on port B (source of the B-to-A path) |
| ab_le | input | 1 | A-to-B latch enable, high selects PASS |
| ab_stb | input | 1 | A-to-B capture strobe, rising edge active |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable, high selects PASS |
| ba_stb | input | 1 | B-to-A capture strobe, rising edge active |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_data | output | WIDTH | Value presented on port B |
| b_drive | output | 1 | 1 when port B is driven, 0 when it is released |
| a_data | output | WIDTH | Value presented on port A |
| a_drive | output | 1 | 1 when port A is driven, 0 when it is released |

## Verification
Every result is due exactly one system clock edge after the inputs that cause it. The data outputs reflect the mode chosen from the control levels seen at that edge. The drive flags reflect the enable level seen at that edge.

The bench changes inputs only on the falling clock edge. At the rising edge it updates its own model from the levels it drives, and it compares all four outputs at the next falling edge. Each comparison therefore looks at the state that a single rising edge produced.

The strobe-edge cases use the strobe value of the previous cycle, which the bench tracks from reset onward. These cases are the capture, the strobe falling without a capture, the latch enable falling with the strobe high, and a strobe already high at reset release.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Action a path's storage element takes at a system clock edge
    typedef enum logic [1:0] {
        PATH_HOLD    = 2'd0,
        PATH_PASS    = 2'd1,
        PATH_CAPTURE = 2'd2
    } path_mode_e;

endpackage

// File: rtl/xcvr_edge_sense.sv
module xcvr_edge_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    output logic rise
);

    logic stb_prev_q;

    // Previous strobe sample resets high so a strobe already high at
    // reset release is not seen as an edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_prev_q <= 1'b1;
        end else begin
            stb_prev_q <= stb;
        end
    end

    assign rise = stb & ~stb_prev_q;

endmodule

// File: rtl/xcvr_mode_ctl.sv
module xcvr_mode_ctl
    import xcvr_pkg::*;
(
    input  logic       le,
    input  logic       rise,
    output path_mode_e mode
);

    always_comb begin
        unique case ({le, rise})
            2'b10, 2'b11: mode = PATH_PASS;
            2'b01:        mode = PATH_CAPTURE;
            2'b00:        mode = PATH_HOLD;
            default:      mode = PATH_HOLD;
        endcase
    end

endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
    import xcvr_pkg::*;
#(
    parameter int unsigned WIDTH          = 18,
    parameter bit          OE_ACTIVE_HIGH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] src,
    input  logic             le,
    input  logic             stb,
    input  logic             oe,
    output logic [WIDTH-1:0] dst,
    output logic             drive
);

    logic             stb_rise;
    path_mode_e       mode;
    logic [WIDTH-1:0] store_q;
    logic             drive_q;
    logic             drive_d;

    xcvr_edge_sense u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (stb),
        .rise  (stb_rise)
    );

    xcvr_mode_ctl u_mode (
        .le   (le),
        .rise (stb_rise),
        .mode (mode)
    );

    // Storage element: one register serving as latch or edge register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store_q <= '0;
        end else begin
            unique case (mode)
                PATH_PASS:    store_q <= src;
                PATH_CAPTURE: store_q <= src;
                PATH_HOLD:    store_q <= store_q;
                default:      store_q <= store_q;
            endcase
        end
    end

    // Enable polarity chosen per direction
    generate
        if (OE_ACTIVE_HIGH) begin : g_oe_high
            assign drive_d = oe;
        end else begin : g_oe_low
            assign drive_d = ~oe;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= 1'b0;
        end else begin
            drive_q <= drive_d;
        end
    end

    assign dst   = store_q;
    assign drive = drive_q;

endmodule

// File: rtl/dual_path_bus_xcvr.sv
module dual_path_bus_xcvr #(
    parameter int unsigned WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_port,
    input  logic [WIDTH-1:0] b_port,
    input  logic             ab_le,
    input  logic             ab_stb,
    input  logic             ab_oe,
    input  logic             ba_le,
    input  logic             ba_stb,
    input  logic             ba_oe_n,
    output logic [WIDTH-1:0] b_data,
    output logic             b_drive,
    output logic [WIDTH-1:0] a_data,
    output logic             a_drive
);

    localparam int unsigned NUM_DIR = 2;  // 0: A-to-B, 1: B-to-A

    logic [WIDTH-1:0] dir_src [NUM_DIR];
    logic [WIDTH-1:0] dir_dst [NUM_DIR];
    logic             dir_le  [NUM_DIR];
    logic             dir_stb [NUM_DIR];
    logic             dir_oe  [NUM_DIR];
    logic             dir_drv [NUM_DIR];

    assign dir_src[0] = a_port;
    assign dir_le[0]  = ab_le;
    assign dir_stb[0] = ab_stb;
    assign dir_oe[0]  = ab_oe;

    assign dir_src[1] = b_port;
    assign dir_le[1]  = ba_le;
    assign dir_stb[1] = ba_stb;
    assign dir_oe[1]  = ba_oe_n;

    generate
        for (genvar gi = 0; gi < NUM_DIR; gi++) begin : g_dir
            xcvr_path #(
                .WIDTH          (WIDTH),
                .OE_ACTIVE_HIGH (gi == 0)
            ) u_path (
                .clk   (clk),
                .rst_n (rst_n),
                .src   (dir_src[gi]),
                .le    (dir_le[gi]),
                .stb   (dir_stb[gi]),
                .oe    (dir_oe[gi]),
                .dst   (dir_dst[gi]),
                .drive (dir_drv[gi])
            );
        end
    endgenerate

    assign b_data  = dir_dst[0];
    assign b_drive = dir_drv[0];
    assign a_data  = dir_dst[1];
    assign a_drive = dir_drv[1];

endmodule

// File: rtl/dual_path_bus_xcvr_chk.sv
module dual_path_bus_xcvr_chk #(
    parameter int unsigned WIDTH = 18
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_port,
    input logic [WIDTH-1:0] b_port,
    input logic             ab_le,
    input logic             ab_stb,
    input logic             ab_oe,
    input logic             ba_le,
    input logic             ba_stb,
    input logic             ba_oe_n,
    input logic [WIDTH-1:0] b_data,
    input logic             b_drive,
    input logic [WIDTH-1:0] a_data,
    input logic             a_drive
);

    // Set once one full cycle out of reset has been sampled
    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |-> (b_data == '0 && a_data == '0 && !b_drive && !a_drive));

    // R2
    ab_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |=> (b_data == $past(a_port)));

    // R2
    ba_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |=> (a_data == $past(b_port)));

    // R3
    ab_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ab_le && ab_stb && !$past(ab_stb)) |=> (b_data == $past(a_port)));

    // R4
    ab_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ab_le && (ab_stb == $past(ab_stb))) |=> $stable(b_data));

    // R5
    ab_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ab_le && !ab_stb && $past(ab_stb)) |=> $stable(b_data));

    // R4
    ba_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !ba_le && (ba_stb == $past(ba_stb))) |=> $stable(a_data));

    // R6
    b_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (b_drive == $past(ab_oe)));

    // R7
    a_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (a_drive == !$past(ba_oe_n)));

endmodule

bind dual_path_bus_xcvr dual_path_bus_xcvr_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .a_port  (a_port),
    .b_port  (b_port),
    .ab_le   (ab_le),
    .ab_stb  (ab_stb),
    .ab_oe   (ab_oe),
    .ba_le   (ba_le),
    .ba_stb  (ba_stb),
    .ba_oe_n (ba_oe_n),
    .b_data  (b_data),
    .b_drive (b_drive),
    .a_data  (a_data),
    .a_drive (a_drive)
);

// File: tb/dual_path_bus_xcvr_tb.sv
module dual_path_bus_xcvr_tb;

    localparam int unsigned W          = 18;
    localparam time         CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_port, b_port;
    logic         ab_le, ab_stb, ab_oe, ba_le, ba_stb, ba_oe_n;
    logic [W-1:0] b_data, a_data;
    logic         b_drive, a_drive;

    int checks = 0;
    int errors = 0;

    // Bench model state
    logic [W-1:0] m_b, m_a;
    logic         m_bd, m_ad, m_pab, m_pba;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_path_bus_xcvr #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_port  (a_port),
        .b_port  (b_port),
        .ab_le   (ab_le),
        .ab_stb  (ab_stb),
        .ab_oe   (ab_oe),
        .ba_le   (ba_le),
        .ba_stb  (ba_stb),
        .ba_oe_n (ba_oe_n),
        .b_data  (b_data),
        .b_drive (b_drive),
        .a_data  (a_data),
        .a_drive (a_drive)
    );

    // Load rule: latch enable high, or strobe seen rising
    function automatic logic loads(logic le, logic stb, logic prev);
        return le || (stb && !prev);
    endfunction

    function automatic logic [W-1:0] rnd_word();
        logic [31:0] r;
        r = $urandom();
        return r[W-1:0];
    endfunction

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // One system cycle: model update at the rising edge, compare at the falling edge
    task automatic tick(string tag);
        @(posedge clk);
        if (!rst_n) begin
            m_b = '0; m_a = '0; m_bd = 1'b0; m_ad = 1'b0;
            m_pab = 1'b1; m_pba = 1'b1;
        end else begin
            if (loads(ab_le, ab_stb, m_pab)) m_b = a_port;
            if (loads(ba_le, ba_stb, m_pba)) m_a = b_port;
            m_pab = ab_stb;
            m_pba = ba_stb;
            m_bd  = ab_oe;
            m_ad  = !ba_oe_n;
        end
        @(negedge clk);
        chk(tag, "b_data", b_data, m_b);
        chk(tag, "a_data", a_data, m_a);
        chk(tag, "b_drive", {{(W-1){1'b0}}, b_drive}, {{(W-1){1'b0}}, m_bd});
        chk(tag, "a_drive", {{(W-1){1'b0}}, a_drive}, {{(W-1){1'b0}}, m_ad});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0;
        a_port = 18'h0_1234; b_port = 18'h2_4321;
        ab_le = 1'b1; ab_stb = 1'b0; ab_oe = 1'b1;
        ba_le = 1'b1; ba_stb = 1'b0; ba_oe_n = 1'b0;
        m_pab = 1'b1; m_pba = 1'b1;
        @(negedge clk);
        tick("R1");
        tick("R1");

        // R10: strobes high across reset release, latch enables low
        ab_le = 1'b0; ba_le = 1'b0; ab_stb = 1'b1; ba_stb = 1'b1;
        ab_oe = 1'b0; ba_oe_n = 1'b1;
        tick("R10");
        rst_n = 1'b1;
        tick("R10");
        tick("R10");

        // R2 pass-through
        ab_le = 1'b1; a_port = 18'h2_AAAA;
        tick("R2");
        a_port = 18'h1_5555;
        tick("R2");

        // R5 latch enable falls while strobe is high
        ab_le = 1'b0; a_port = 18'h3_0F0F;
        tick("R5");
        // R4 strobe held high
        a_port = 18'h0_3C3C;
        tick("R4");
        // R5 strobe falling: no load
        ab_stb = 1'b0; a_port = 18'h1_1111;
        tick("R5");
        // R4 strobe held low
        a_port = 18'h2_2222;
        tick("R4");
        // R3 rising strobe captures
        ab_stb = 1'b1; a_port = 18'h3_ABCD;
        tick("R3");
        a_port = 18'h0_0001;
        tick("R4");

        // R5 latch enable falls while strobe is low
        ab_stb = 1'b0; ab_le = 1'b1; a_port = 18'h1_2345;
        tick("R2");
        ab_le = 1'b0; a_port = 18'h3_FFFF;
        tick("R5");

        // R6 / R7 drive polarity
        ab_oe = 1'b1;
        tick("R6");
        ab_oe = 1'b0;
        tick("R6");
        ba_oe_n = 1'b0;
        tick("R7");
        ba_oe_n = 1'b1;
        tick("R7");

        // R8 storage moves while port B released
        ab_oe = 1'b0; ab_le = 1'b1; a_port = 18'h2_5A5A;
        tick("R8");
        ab_le = 1'b0; ab_oe = 1'b1;
        tick("R8");

        // R9 B-to-A capture while A-to-B holds
        ba_stb = 1'b0; a_port = 18'h0_7777;
        tick("R9");
        ba_stb = 1'b1; b_port = 18'h1_9999;
        tick("R9");
        ba_le = 1'b1; b_port = 18'h2_0C0C; ab_stb = 1'b0;
        tick("R9");

        // Mixed random traffic on both paths
        for (int i = 0; i < 2000; i++) begin
            a_port  = rnd_word();
            b_port  = rnd_word();
            ab_le   = ($urandom() % 5) == 0;
            ba_le   = ($urandom() % 5) == 0;
            ab_stb  = ($urandom() % 2) == 0;
            ba_stb  = ($urandom() % 3) == 0;
            ab_oe   = ($urandom() % 2) == 0;
            ba_oe_n = ($urandom() % 2) == 0;
            tick("R9");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule